// File: doc/BRIEF.md
# Split Reversible Word Incrementer

This block adds one to an N-bit word using only reversible stages: bitwise NOTs, single-control XORs, and XORs controlled by the AND of several wires. Each stage XORs into a wire that is not one of its own controls, so the whole network can be undone stage by stage. The word is cut into a low part of ceil(N/2) bits and a high part holding the rest. One extra wire, the helper bit, carries the "low part is all ones" condition into the high part. This way the high-part stages never take the whole low part as controls.

A parameter picks how the helper bit is treated:
- In *scratch* mode the helper is assumed to start at 0 and is left holding the low-part AND.
- In *clean* mode the helper is also assumed to start at 0, and a last stage uncomputes it.
- In *loaned* mode the helper may hold any value and always comes back unchanged. Here the high part is first complemented under the helper, which turns the helper-controlled advances into retreats. A decrement under the helper comes before the helper toggle and an increment under the helper comes after it. The net change is +1 exactly when the low part was all ones.

The word and helper bit are sampled into output registers each clock. The result appears one cycle after the inputs are applied.

Top module: `rinc_split_incr`

## Requirements
- R1: Synchronous active-high reset clears `word_o` and `help_o` to 0. Outside reset, the outputs show the network result for the inputs sampled at the previous rising clock edge.
- R2: In loaned mode (MODE = RINC_LOANED), `word_o` equals `word_i + 1` modulo 2^N for either value of `help_i`, and all ones wraps to zero.
- R3: In scratch mode (MODE = RINC_SCRATCH) with `help_i` = 0, `word_o` equals `word_i + 1` modulo 2^N.
- R4: In scratch and clean modes, the high part advances by one exactly when `help_i` XOR (low part all ones) is 1. With `help_i` = 1 the high part therefore advances when the low part is not all ones.
- R5: In scratch mode, `help_o` equals `help_i` XOR the AND of the low-part bits.
- R6: In clean mode (MODE = RINC_CLEAN) and in loaned mode, `help_o` equals `help_i`. A clean-mode helper that enters at 0 leaves at 0.
- R7: In every mode, the low part `word_o[LO-1:0]` equals `word_i[LO-1:0] + 1` modulo 2^LO, independent of `help_i` and of the high part.
- R8: The low part has LO = ceil(N/2) bits. For odd N = 5 the low part is bits 2..0, so in scratch mode `help_o` rises for `word_i` = 5'b00111 and stays low for 5'b00011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | N | Word to increment |
| help_i | input | 1 | Helper (ancilla) bit entering the network |
| word_o | output | N | Registered result word |
| help_o | output | 1 | Registered helper bit leaving the network |

## Verification
Every one of the 2^N words is applied with the helper at 0 and at 1 to one instance of each mode. The all-ones low parts separate a correct carry into the high part from a missing or doubled one. Words whose low part is one short of all ones show whether the high part moves too early. Driving the helper at 1 separates the loaned construction, which must cancel the helper, from the scratch and clean ones, which let it steer the high part. Random words with a fixed seed then repeat the comparison against a bench model.

// File: rtl/rinc_pkg.sv
package rinc_pkg;
  typedef enum logic [1:0] {
    RINC_SCRATCH = 2'd0,
    RINC_CLEAN   = 2'd1,
    RINC_LOANED  = 2'd2
  } help_mode_e;
endpackage

// File: rtl/rinc_inc.sv
// Controlled increment as a cascade of reversible stages. Stage k targets
// bit W-1-k and is controlled by ctl_i and every lower bit of the current
// word, so no stage writes a wire it reads.
module rinc_inc #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic         ctl_i,
  output logic [W-1:0] x_o
);
  logic [W:0][W-1:0] v;

  assign v[0] = x_i;

  for (genvar k = 0; k < W; k++) begin : g_stage
    localparam int T = W - 1 - k;
    logic flip;
    if (T == 0) begin : g_lsb
      assign flip = ctl_i;
    end else begin : g_mid
      assign flip = ctl_i & (&v[k][T-1:0]);
    end
    for (genvar j = 0; j < W; j++) begin : g_bit
      if (j == T) begin : g_tgt
        assign v[k+1][j] = v[k][j] ^ flip;
      end else begin : g_pass
        assign v[k+1][j] = v[k][j];
      end
    end
  end

  assign x_o = v[W];
endmodule

// File: rtl/rinc_cpl.sv
// Fan of single-control XORs: complements the whole word when c_i is set.
module rinc_cpl #(
  parameter int W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic         c_i,
  output logic [W-1:0] x_o
);
  assign x_o = x_i ^ {W{c_i}};
endmodule

// File: rtl/rinc_split_incr.sv
module rinc_split_incr #(
  parameter int                   N    = 5,
  parameter rinc_pkg::help_mode_e MODE = rinc_pkg::RINC_LOANED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] word_i,
  input  logic         help_i,
  output logic [N-1:0] word_o,
  output logic         help_o
);
  localparam int LO = (N + 1) / 2;
  localparam int HI = N - LO;

  logic [LO-1:0] lo_in, lo_nx;
  logic [HI-1:0] hi_in, hi_nx;
  logic          lo_full;
  logic          help_nx;

  assign lo_in   = word_i[LO-1:0];
  assign hi_in   = word_i[N-1:LO];
  assign lo_full = &lo_in;

  // Low part: plain increment, placed after all stages that read it.
  rinc_inc #(.W(LO)) u_lo_inc (.x_i(lo_in), .ctl_i(1'b1), .x_o(lo_nx));

  if (MODE == rinc_pkg::RINC_LOANED) begin : g_loaned
    logic [HI-1:0] h0, h1, h2, h3, h4, h5;
    logic          hb1, hb2;

    // outer sandwich: complement high part under the helper
    rinc_cpl #(.W(HI)) u_pre  (.x_i(hi_in), .c_i(help_i), .x_o(h0));
    // decrement under the helper = complement, controlled inc, complement
    rinc_cpl #(.W(HI)) u_d0   (.x_i(h0), .c_i(help_i), .x_o(h1));
    rinc_inc #(.W(HI)) u_dinc (.x_i(h1), .ctl_i(help_i), .x_o(h2));
    rinc_cpl #(.W(HI)) u_d1   (.x_i(h2), .c_i(help_i), .x_o(h3));
    // toggle helper by the low-part AND
    assign hb1 = help_i ^ lo_full;
    // increment under the toggled helper
    rinc_inc #(.W(HI)) u_iinc (.x_i(h3), .ctl_i(hb1), .x_o(h4));
    // restore helper
    assign hb2 = hb1 ^ lo_full;
    rinc_cpl #(.W(HI)) u_post (.x_i(h4), .c_i(hb2), .x_o(h5));

    assign hi_nx   = h5;
    assign help_nx = hb2;
  end else begin : g_direct
    logic hb1;
    assign hb1 = help_i ^ lo_full;
    rinc_inc #(.W(HI)) u_hinc (.x_i(hi_in), .ctl_i(hb1), .x_o(hi_nx));
    if (MODE == rinc_pkg::RINC_CLEAN) begin : g_unc
      assign help_nx = hb1 ^ lo_full;
    end else begin : g_keep
      assign help_nx = hb1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      help_o <= 1'b0;
    end else begin
      word_o <= {hi_nx, lo_nx};
      help_o <= help_nx;
    end
  end
endmodule

// File: rtl/rinc_split_incr_chk.sv
module rinc_split_incr_chk #(
  parameter int                   N    = 5,
  parameter rinc_pkg::help_mode_e MODE = rinc_pkg::RINC_LOANED
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] word_i,
  input logic         help_i,
  input logic [N-1:0] word_o,
  input logic         help_o
);
  localparam int LO = (N + 1) / 2;

  logic live;
  always_ff @(posedge clk) live <= !rst;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (word_o == '0 && help_o == 1'b0));

  // R2
  a_r2_loaned_plus_one: assert property (@(posedge clk) disable iff (rst)
    (MODE == rinc_pkg::RINC_LOANED && live) |->
      word_o == N'($past(word_i) + 1'b1));

  // R5
  a_r5_scratch_flag: assert property (@(posedge clk) disable iff (rst)
    (MODE == rinc_pkg::RINC_SCRATCH && live) |->
      help_o == ($past(help_i) ^ (&$past(word_i[LO-1:0]))));

  // R6
  a_r6_helper_back: assert property (@(posedge clk) disable iff (rst)
    (MODE != rinc_pkg::RINC_SCRATCH && live) |-> help_o == $past(help_i));

  // R7
  a_r7_low_part: assert property (@(posedge clk) disable iff (rst)
    live |-> word_o[LO-1:0] == LO'($past(word_i[LO-1:0]) + 1'b1));
endmodule

bind rinc_split_incr rinc_split_incr_chk #(.N(N), .MODE(MODE)) u_chk (.*);

// File: tb/rinc_split_incr_tb.sv
module rinc_split_incr_tb;
  localparam int N  = 5;
  localparam int LO = (N + 1) / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] w_in = '0;
  logic         h_in = 1'b0;
  logic [N-1:0] w_ln, w_cl, w_sc;
  logic         h_ln, h_cl, h_sc;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rinc_split_incr #(.N(N), .MODE(rinc_pkg::RINC_LOANED)) u_dut (
    .clk(clk), .rst(rst), .word_i(w_in), .help_i(h_in), .word_o(w_ln), .help_o(h_ln));
  rinc_split_incr #(.N(N), .MODE(rinc_pkg::RINC_CLEAN)) u_dut_cl (
    .clk(clk), .rst(rst), .word_i(w_in), .help_i(h_in), .word_o(w_cl), .help_o(h_cl));
  rinc_split_incr #(.N(N), .MODE(rinc_pkg::RINC_SCRATCH)) u_dut_sc (
    .clk(clk), .rst(rst), .word_i(w_in), .help_i(h_in), .word_o(w_sc), .help_o(h_sc));

  // model: mode 0 scratch, 1 clean, 2 loaned
  function automatic logic [N-1:0] exp_word(int mode, logic [N-1:0] w, logic h);
    logic [LO-1:0]   lo;
    logic [N-LO-1:0] hi;
    logic            adv;
    lo  = w[LO-1:0];
    hi  = w[N-1:LO];
    adv = (mode == 2) ? (&lo) : (h ^ (&lo));
    return {hi + (N-LO)'(adv), lo + LO'(1)};
  endfunction

  function automatic logic exp_help(int mode, logic [N-1:0] w, logic h);
    return (mode == 0) ? (h ^ (&w[LO-1:0])) : h;
  endfunction

  task automatic chk(string req, logic [N:0] act, logic [N:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s in=%b h=%b actual=%b expected=%b", req, w_in, h_in, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] w, logic h);
    @(negedge clk);
    w_in = w;
    h_in = h;
    @(negedge clk);
    // R2 R6: loaned word and helper
    chk("R2", {1'b0, w_ln}, {1'b0, exp_word(2, w, h)});
    chk("R6", {{N{1'b0}}, h_ln}, {{N{1'b0}}, h}); // R6 loaned helper
    // R4 R6: clean
    chk(h ? "R4" : "R7", {1'b0, w_cl}, {1'b0, exp_word(1, w, h)});
    chk("R6", {{N{1'b0}}, h_cl}, {{N{1'b0}}, exp_help(1, w, h)});
    // R3 R4 R5: scratch
    chk(h ? "R4" : "R3", {1'b0, w_sc}, {1'b0, exp_word(0, w, h)});
    chk("R5", {{N{1'b0}}, h_sc}, {{N{1'b0}}, exp_help(0, w, h)});
  endtask

  initial begin : watchdog
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    w_in = 5'b11111;
    h_in = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", {w_ln, h_ln}, '0);
    chk("R1", {w_cl, h_cl}, '0);
    chk("R1", {w_sc, h_sc}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R8: odd split, low part is bits 2..0
    apply(5'b00111, 1'b0);
    chk("R8", {{N{1'b0}}, h_sc}, {{N{1'b0}}, 1'b1});
    apply(5'b00011, 1'b0);
    chk("R8", {{N{1'b0}}, h_sc}, '0);
    // R2: full wrap
    apply(5'b11111, 1'b0);
    chk("R2", {1'b0, w_ln}, '0);
    apply(5'b11111, 1'b1);
    chk("R2", {1'b0, w_ln}, '0);

    // exhaustive sweep, both helper values
    for (int hv = 0; hv < 2; hv++) begin
      for (int v = 0; v < (1 << N); v++) begin
        apply(N'(v), hv[0]);
      end
    end

    // random mix
    for (int i = 0; i < 200; i++) begin
      apply(N'($urandom), 1'($urandom));
    end

    // R1: reset again clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {w_ln, h_ln}, '0);
    chk("R1", {w_sc, h_sc}, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule